// File: doc/BRIEF.md
# Programmable Modulus Count-to-Zero Divider

This block divides a clock-enable stream by a period that software may change while it runs. A down-counter is loaded with the period minus two and counts through zero into minus one. The top bit of the counter, which is the two's-complement sign, marks the last state of each period. While that bit is set, the next enabled cycle reloads the counter. No magnitude comparator is involved at any point. The extra minus-one state is the reason the load value is two below the period.

A period register captures a new value on a write strobe. The counter reads that register only at a reload and in the single priming cycle after reset is released. A new period therefore never shortens or stretches the period already in progress. Two parameters shape the terminal-count output: one selects a direct or a flip-flop output, the other selects high or low as the active level.

Top module: `cz_divider`

## Requirements
- R1: With count enable held high and period P loaded, `count_out` (two's complement, PERIOD_W+1 bits) steps down by one per cycle from P-2 to 0, then to -1, then reloads P-2. One period is P enabled cycles. For P=7 the values are 5,4,3,2,1,0,-1,5.
- R2: With TC_REGISTERED=0, the terminal-count output is at its active level in exactly the cycles where count enable is high, the counter is at -1 and the block is not priming. The counter never holds any negative value other than -1.
- R3: With TC_REGISTERED=1, the terminal-count output shows, one clock later, the condition that R2 defines.
- R4: TC_ACTIVE_LOW=0 makes the active level 1. TC_ACTIVE_LOW=1 makes it 0 and inverts the idle level.
- R5: A high `period_wr` at a clock edge stores `period_in` in the period register. A reload at that same edge still uses the previous period. The new period governs only reloads from the next terminal count onward.
- R6: On the first cycle after reset is released, the counter loads (period register - 2) whatever the count enable is. During that cycle there is no terminal count.
- R7: While count enable is low, `count_out` holds its value and no terminal count is produced.
- R8: A written period below 2 is stored as 2. The counter then alternates 0,-1.
- R9: While reset is high, `count_out` is 0, the terminal-count output is inactive and the period register returns to 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Count enable |
| period_in | input | PERIOD_W | Requested period |
| period_wr | input | 1 | Write strobe for the period register |
| tc_out | output | 1 | Terminal-count pulse, formatted by the parameters |
| count_out | output | PERIOD_W+1 | Current counter value, two's complement |

## Verification
A wrong load value or a wrong reload moment shows up on `count_out` at the very next clock edge. A stale or early period shows up at the first reload after a write, because the count then restarts from the wrong value. A lost sign-bit decode shows up as a missing or extra terminal-count pulse in the cycle the counter sits at -1, one cycle later in the registered variant. The bench runs a behavioural model next to two instances, one per output format, and compares every port on every clock.

// File: rtl/cz_pkg.sv
package cz_pkg;

    // Smallest period the counter can represent: one step at 0, one at -1.
    localparam int MIN_PERIOD = 2;

    // Action the counter takes on the coming edge.
    typedef enum logic [1:0] {
        ACT_HOLD   = 2'd0,
        ACT_STEP   = 2'd1,
        ACT_RELOAD = 2'd2
    } cnt_act_e;

    // Decoded state of the counter that drives the action choice.
    typedef struct packed {
        logic priming;
        logic enabled;
        logic expired;
    } cnt_status_t;

    function automatic cnt_act_e pick_action(input cnt_status_t st);
        if (st.priming)      return ACT_RELOAD;
        else if (!st.enabled) return ACT_HOLD;
        else if (st.expired)  return ACT_RELOAD;
        else                  return ACT_STEP;
    endfunction

endpackage

// File: rtl/cz_period_reg.sv
module cz_period_reg #(
    parameter int PERIOD_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [PERIOD_W-1:0] wr_data,
    output logic [PERIOD_W-1:0] period_q
);
    import cz_pkg::*;

    localparam logic [PERIOD_W-1:0] FLOOR = PERIOD_W'(MIN_PERIOD);

    logic [PERIOD_W-1:0] clamped;

    always_comb begin
        clamped = (wr_data < FLOOR) ? FLOOR : wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            period_q <= FLOOR;
        end else if (wr_en) begin
            period_q <= clamped;
        end
    end

endmodule

// File: rtl/cz_down_counter.sv
module cz_down_counter #(
    parameter int PERIOD_W = 8,
    localparam int CW      = PERIOD_W + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic [PERIOD_W-1:0] period,
    output logic [CW-1:0]       count_q,
    output logic                prime_q,
    output logic                tc_raw
);
    import cz_pkg::*;

    cnt_status_t    status;
    cnt_act_e       act;
    logic [CW-1:0]  reload_val;

    always_comb begin
        reload_val     = {1'b0, period} - CW'(MIN_PERIOD);
        status.priming = prime_q;
        status.enabled = en;
        status.expired = count_q[CW-1];
        act            = pick_action(status);
        tc_raw         = en & ~prime_q & count_q[CW-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            prime_q <= 1'b1;
        end else begin
            prime_q <= 1'b0;
            case (act)
                ACT_RELOAD: count_q <= reload_val;
                ACT_STEP:   count_q <= count_q - CW'(1);
                default:    count_q <= count_q;
            endcase
        end
    end

endmodule

// File: rtl/cz_tc_format.sv
module cz_tc_format #(
    parameter bit TC_REGISTERED = 1'b0,
    parameter bit TC_ACTIVE_LOW = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic tc_raw,
    output logic tc_out
);
    logic tc_level;

    generate
        if (TC_REGISTERED) begin : g_reg
            logic tc_q;
            always_ff @(posedge clk) begin
                if (rst) tc_q <= 1'b0;
                else     tc_q <= tc_raw;
            end
            assign tc_level = tc_q;
        end else begin : g_comb
            assign tc_level = tc_raw;
        end

        if (TC_ACTIVE_LOW) begin : g_low
            assign tc_out = ~tc_level;
        end else begin : g_high
            assign tc_out = tc_level;
        end
    endgenerate

endmodule

// File: rtl/cz_divider.sv
module cz_divider #(
    parameter int PERIOD_W      = 8,
    parameter bit TC_REGISTERED = 1'b0,
    parameter bit TC_ACTIVE_LOW = 1'b0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cnt_en,
    input  logic [PERIOD_W-1:0] period_in,
    input  logic                period_wr,
    output logic                tc_out,
    output logic [PERIOD_W:0]   count_out
);
    logic [PERIOD_W-1:0] period_q;
    logic                prime_q;
    logic                tc_raw;

    cz_period_reg #(.PERIOD_W(PERIOD_W)) u_period (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (period_wr),
        .wr_data  (period_in),
        .period_q (period_q)
    );

    cz_down_counter #(.PERIOD_W(PERIOD_W)) u_count (
        .clk     (clk),
        .rst     (rst),
        .en      (cnt_en),
        .period  (period_q),
        .count_q (count_out),
        .prime_q (prime_q),
        .tc_raw  (tc_raw)
    );

    cz_tc_format #(
        .TC_REGISTERED (TC_REGISTERED),
        .TC_ACTIVE_LOW (TC_ACTIVE_LOW)
    ) u_fmt (
        .clk    (clk),
        .rst    (rst),
        .tc_raw (tc_raw),
        .tc_out (tc_out)
    );

endmodule

// File: rtl/cz_divider_chk.sv
module cz_divider_chk #(
    parameter int PERIOD_W      = 8,
    parameter bit TC_REGISTERED = 1'b0,
    parameter bit TC_ACTIVE_LOW = 1'b0,
    localparam int CW           = PERIOD_W + 1
) (
    input logic                clk,
    input logic                rst,
    input logic                cnt_en,
    input logic                tc_out,
    input logic [CW-1:0]       count_out,
    input logic [PERIOD_W-1:0] period_q,
    input logic                prime_q
);
    logic          tc_act;
    logic          expect_tc;
    logic [CW-1:0] reload_val;

    assign tc_act     = TC_ACTIVE_LOW ? ~tc_out : tc_out;
    assign expect_tc  = cnt_en & ~prime_q & count_out[CW-1];
    assign reload_val = {1'b0, period_q} - CW'(2);

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && !prime_q && !count_out[CW-1]) |=> (count_out == $past(count_out) - CW'(1)))
        else $error("step down"); // R1

    AST_ONLY_MINUS_ONE: assert property (@(posedge clk) disable iff (rst)
        count_out[CW-1] |-> (&count_out))
        else $error("negative value other than -1"); // R2

    AST_RELOAD_OLD_PERIOD: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && !prime_q && count_out[CW-1]) |=> (count_out == $past(reload_val)))
        else $error("reload value"); // R5

    AST_PRIME_LOAD: assert property (@(posedge clk) disable iff (rst)
        prime_q |=> (count_out == $past(reload_val)))
        else $error("priming load"); // R6

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!cnt_en && !prime_q) |=> $stable(count_out))
        else $error("count moved while idle"); // R7

    AST_PERIOD_FLOOR: assert property (@(posedge clk) disable iff (rst)
        period_q >= PERIOD_W'(2))
        else $error("period below floor"); // R8

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (count_out == '0 && !tc_act))
        else $error("reset state"); // R9

    generate
        if (TC_REGISTERED) begin : g_reg_chk
            AST_TC_DELAYED: assert property (@(posedge clk) disable iff (rst)
                1'b1 |=> (tc_act == $past(expect_tc)))
                else $error("registered terminal count"); // R3
        end else begin : g_comb_chk
            AST_TC_DIRECT: assert property (@(posedge clk) disable iff (rst)
                tc_act == expect_tc)
                else $error("direct terminal count"); // R2
        end
    endgenerate

endmodule

bind cz_divider cz_divider_chk #(
    .PERIOD_W      (PERIOD_W),
    .TC_REGISTERED (TC_REGISTERED),
    .TC_ACTIVE_LOW (TC_ACTIVE_LOW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cnt_en    (cnt_en),
    .tc_out    (tc_out),
    .count_out (count_out),
    .period_q  (period_q),
    .prime_q   (prime_q)
);

// File: tb/cz_divider_tb.sv
module cz_divider_tb;
    localparam int PW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cnt_en = 1'b0;
    logic [PW-1:0] period_in = '0;
    logic          period_wr = 1'b0;
    logic          tc_a, tc_b;
    logic [PW:0]   cnt_a, cnt_b;

    int checks = 0;
    int errors = 0;
    string phase = "R9 reset";

    // Model state
    int m_per = 2;
    int m_cnt = 0;
    bit m_prime = 1'b1;
    bit m_rawq = 1'b0;

    always #4 clk = ~clk;

    // Direct output, active high
    cz_divider #(.PERIOD_W(PW), .TC_REGISTERED(1'b0), .TC_ACTIVE_LOW(1'b0)) u_dut (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .period_in(period_in),
        .period_wr(period_wr), .tc_out(tc_a), .count_out(cnt_a)
    );

    // Registered output, active low (R3, R4)
    cz_divider #(.PERIOD_W(PW), .TC_REGISTERED(1'b1), .TC_ACTIVE_LOW(1'b1)) u_dut_rl (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .period_in(period_in),
        .period_wr(period_wr), .tc_out(tc_b), .count_out(cnt_b)
    );

    // Behavioural reference, updated on each rising edge
    always @(posedge clk) begin
        bit raw_now;
        int old_per;
        if (rst) begin
            m_per = 2; m_cnt = 0; m_prime = 1'b1; m_rawq = 1'b0;
        end else begin
            old_per = m_per;
            raw_now = cnt_en && !m_prime && (m_cnt < 0);
            if (m_prime) begin
                m_cnt = old_per - 2;
                m_prime = 1'b0;
            end else if (cnt_en) begin
                m_cnt = (m_cnt < 0) ? old_per - 2 : m_cnt - 1;
            end
            if (period_wr) m_per = (int'(period_in) < 2) ? 2 : int'(period_in);
            m_rawq = raw_now;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare on every falling edge
    always @(negedge clk) begin
        bit exp_raw;
        exp_raw = cnt_en && !m_prime && (m_cnt < 0) && !rst;
        check({phase, " R1 count direct"}, int'($signed(cnt_a)), m_cnt);
        check({phase, " R1 count registered"}, int'($signed(cnt_b)), m_cnt);
        check({phase, " R2 R4 tc direct active-high"}, int'(tc_a), int'(exp_raw));
        check({phase, " R3 R4 tc registered active-low"}, int'(tc_b), int'(!m_rawq));
    end

    task automatic run(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic write_period(input int p);
        period_in = PW'(p);
        period_wr = 1'b1;
        run(1);
        period_wr = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        run(3);
        // R6: release reset, period register holds its reset value 2
        phase = "R6 prime";
        rst = 1'b0;
        cnt_en = 1'b1;
        run(8);
        // R5: new period takes effect at next reload
        phase = "R5 write";
        write_period(7);
        run(20);
        // R5: write in mid-period must not disturb the running count
        wait (m_cnt == 3);
        #1;
        write_period(4);
        run(16);
        // R7: enable low holds, including at -1
        phase = "R7 hold";
        cnt_en = 1'b0;
        run(5);
        cnt_en = 1'b1;
        wait (m_cnt < 0);
        #1;
        cnt_en = 1'b0;
        run(4);
        cnt_en = 1'b1;
        run(6);
        // R8: clamp of small requests
        phase = "R8 clamp";
        write_period(1);
        run(10);
        write_period(0);
        run(10);
        // R1: divide by seven
        phase = "R1 div7";
        write_period(7);
        run(30);
        // R1: largest period
        phase = "R1 max";
        write_period(255);
        run(600);
        // R9: reset mid-run restores period 2
        phase = "R9 reset";
        write_period(5);
        run(3);
        rst = 1'b1;
        run(3);
        // R6: priming happens even with enable low
        phase = "R6 prime idle";
        cnt_en = 1'b0;
        rst = 1'b0;
        run(4);
        cnt_en = 1'b1;
        run(10);
        // R5: write on the same edge as a reload
        phase = "R5 same edge";
        write_period(9);
        run(4);
        wait (m_cnt < 0);
        #1;
        write_period(3);
        run(20);
        finish_run();
    end

endmodule